// File: doc/BRIEF.md
# GPIO Keyboard Scan-Code Injector

This block turns activity on a small bank of general-purpose input pins into keyboard scan-code bytes for a keyboard controller. Each pin passes through a two-flop synchroniser and an edge detector. A rising level is a key press and a falling level is a key release. Each edge is held as a pending event for its pin.

A sequencer serves pending events in fixed priority, lowest pin first. For a press it sends the pin's programmed make code. For a release it sends that code plus 0x80. If the pin's prefix-enable bit is set, a programmable prefix byte goes out first. The bytes pass through a single one-byte output buffer with a full flag. The host clears the flag with a read strobe, and only then is the next byte loaded.

Software programs the codes through a byte-wide register port. Reads from this port are combinational.

Top module: `gpio_scan_inject`

## Requirements
- R1: After reset, `obuf_full` is 0, every make-code register reads 0x00, every prefix register reads 0xE0, and the prefix-enable register reads 0x00.
- R2: The make code for pin i is at address 0xD8+i, and the prefix byte for pin i is at 0xC8+i. The prefix-enable register is at 0xD0, where bit i controls pin i. Writes store the byte, and reads return it on the same cycle. Any other address reads 0x00, and a write to it changes no register.
- R3: A 0-to-1 change on pin i, after two-flop synchronisation, produces one byte equal to pin i's make code.
- R4: A 1-to-0 change on pin i produces one byte equal to (make code + 0x80) mod 256.
- R5: When bit i of the prefix-enable register is 1, each event of pin i produces two bytes: first the prefix byte, then the make or break byte.
- R6: Each byte loaded into the buffer sets `obuf_full`. While `obuf_full` is 1 and `obuf_rd` is 0, `obuf_data` and `obuf_full` hold their values.
- R7: When `obuf_rd` is high while `obuf_full` is 1, the flag is cleared on the next cycle. A new byte can load at the earliest one cycle after that.
- R8: When several pins have events pending, the lowest-numbered pin is served first.
- R9: Once a prefix byte has been sent, the next byte delivered is the code byte of the same event, even if higher-priority events arrive in between.
- R10: Each pin holds at most one pending press and one pending release, and they are delivered oldest first. A repeated edge of a type that is already pending merges into it and becomes the newest. So a press, release, press sequence that stays pending delivers a break byte and then a make byte.
- R11: While the pins stay steady, no byte is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | N_PINS | Asynchronous key input pins |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| obuf_rd | input | 1 | Host read strobe; clears the full flag |
| obuf_data | output | 8 | Output buffer byte |
| obuf_full | output | 1 | Output buffer full flag |

## Verification
The assertions check on every cycle that the buffer is held while full and unread, that a read clears the flag, that a pending tail byte is always the next byte loaded, and that unmapped addresses read as zero. Only the bench scenarios can show that byte values and their order are correct across several pins: the make and break arithmetic including wrap-around, prefix insertion, lowest-pin priority, and the merging of repeated edges into a pending press or release.

// File: rtl/gsi_pkg.sv
package gsi_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_TAIL = 1'b1} seq_state_e;
  localparam byte_t BREAK_OFFSET = 8'h80;
  localparam byte_t PRE_RESET    = 8'hE0;
endpackage

// File: rtl/gsi_sync_edge.sv
module gsi_sync_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gsi_regfile.sv
module gsi_regfile
  import gsi_pkg::*;
#(
  parameter int unsigned N         = 8,
  parameter logic [7:0]  MAKE_BASE = 8'hD8,
  parameter logic [7:0]  PRE_BASE  = 8'hC8,
  parameter logic [7:0]  EN_ADDR   = 8'hD0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            addr_i,
  input  logic                  wr_i,
  input  byte_t                 wdata_i,
  output byte_t                 rdata_o,
  output logic [N-1:0][BYTE_W-1:0] make_o,
  output logic [N-1:0][BYTE_W-1:0] pre_o,
  output logic [N-1:0]          pre_en_o
);
  logic [N-1:0][BYTE_W-1:0] make_q, make_d, pre_q, pre_d;
  logic [N-1:0]             en_q, en_d;

  always_comb begin
    make_d  = make_q;
    pre_d   = pre_q;
    en_d    = en_q;
    rdata_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (addr_i == 8'(MAKE_BASE + i)) begin
        rdata_o = make_q[i];
        if (wr_i) make_d[i] = wdata_i;
      end
      if (addr_i == 8'(PRE_BASE + i)) begin
        rdata_o = pre_q[i];
        if (wr_i) pre_d[i] = wdata_i;
      end
    end
    if (addr_i == EN_ADDR) begin
      rdata_o = 8'(en_q);
      if (wr_i) en_d = wdata_i[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      make_q <= '0;
      pre_q  <= {N{PRE_RESET}};
      en_q   <= '0;
    end else if (wr_i) begin
      make_q <= make_d;
      pre_q  <= pre_d;
      en_q   <= en_d;
    end
  end

  assign make_o   = make_q;
  assign pre_o    = pre_q;
  assign pre_en_o = en_q;
endmodule

// File: rtl/gsi_pending.sv
module gsi_pending #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] clr_mk_i,
  input  logic [N-1:0] clr_brk_i,
  output logic [N-1:0] mk_o,
  output logic [N-1:0] brk_o,
  output logic [N-1:0] brk_first_o
);
  for (genvar g = 0; g < int'(N); g++) begin : g_pin
    logic mk_q, brk_q, first_q;
    logic mk_d, brk_d, first_d, mk_left, brk_left;

    always_comb begin
      mk_left  = mk_q & ~clr_mk_i[g];
      brk_left = brk_q & ~clr_brk_i[g];
      mk_d     = mk_left | rise_i[g];
      brk_d    = brk_left | fall_i[g];
      first_d  = first_q;
      if (rise_i[g])      first_d = brk_left;   // release older if still pending
      else if (fall_i[g]) first_d = ~mk_left;   // press older if still pending
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mk_q    <= 1'b0;
        brk_q   <= 1'b0;
        first_q <= 1'b0;
      end else begin
        mk_q    <= mk_d;
        brk_q   <= brk_d;
        first_q <= first_d;
      end
    end

    assign mk_o[g]        = mk_q;
    assign brk_o[g]       = brk_q;
    assign brk_first_o[g] = first_q;
  end
endmodule

// File: rtl/gsi_sequencer.sv
module gsi_sequencer
  import gsi_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             mk_i,
  input  logic [N-1:0]             brk_i,
  input  logic [N-1:0]             brk_first_i,
  input  logic [N-1:0][BYTE_W-1:0] make_i,
  input  logic [N-1:0][BYTE_W-1:0] pre_i,
  input  logic [N-1:0]             pre_en_i,
  input  logic                     rd_i,
  output logic [N-1:0]             clr_mk_o,
  output logic [N-1:0]             clr_brk_o,
  output byte_t                    obuf_data_o,
  output logic                     obuf_full_o,
  output logic                     tail_pend_o,
  output byte_t                    tail_byte_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  seq_state_e        state_q, state_d;
  byte_t             tail_q, tail_d, data_q, data_d;
  logic              full_q, full_d;
  logic [IDX_W-1:0]  sel;
  logic              any, is_brk;
  byte_t             code;

  always_comb begin
    any = |(mk_i | brk_i);
    sel = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (mk_i[i] | brk_i[i]) sel = IDX_W'(i);
    end
    is_brk = (mk_i[sel] & brk_i[sel]) ? brk_first_i[sel] : brk_i[sel];
    code   = is_brk ? byte_t'(make_i[sel] + BREAK_OFFSET) : make_i[sel];
  end

  always_comb begin
    state_d   = state_q;
    tail_d    = tail_q;
    data_d    = data_q;
    full_d    = full_q & ~rd_i;
    clr_mk_o  = '0;
    clr_brk_o = '0;
    if (!full_q) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (any) begin
            if (is_brk) clr_brk_o[sel] = 1'b1;
            else        clr_mk_o[sel]  = 1'b1;
            full_d = 1'b1;
            if (pre_en_i[sel]) begin
              data_d  = pre_i[sel];
              tail_d  = code;
              state_d = SEQ_TAIL;
            end else begin
              data_d = code;
            end
          end
        end
        SEQ_TAIL: begin
          data_d  = tail_q;
          full_d  = 1'b1;
          state_d = SEQ_IDLE;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tail_q  <= '0;
      data_q  <= '0;
      full_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tail_q  <= tail_d;
      full_q  <= full_d;
      if (!full_q) data_q <= data_d;
    end
  end

  assign obuf_data_o = data_q;
  assign obuf_full_o = full_q;
  assign tail_pend_o = (state_q == SEQ_TAIL);
  assign tail_byte_o = tail_q;
endmodule

// File: rtl/gpio_scan_inject.sv
module gpio_scan_inject
  import gsi_pkg::*;
#(
  parameter int unsigned N_PINS    = 8,
  parameter logic [7:0]  MAKE_BASE = 8'hD8,
  parameter logic [7:0]  PRE_BASE  = 8'hC8,
  parameter logic [7:0]  EN_ADDR   = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] gpio_in,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              obuf_rd,
  output logic [7:0]        obuf_data,
  output logic              obuf_full
);
  logic [N_PINS-1:0]             rise, fall, mk, brk, brk_first, clr_mk, clr_brk, pre_en;
  logic [N_PINS-1:0][BYTE_W-1:0] make_codes, pre_codes;
  logic                          seq_tail_pend;
  byte_t                         seq_tail_byte;

  gsi_sync_edge #(.N(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(gpio_in), .rise_o(rise), .fall_o(fall)
  );

  gsi_regfile #(.N(N_PINS), .MAKE_BASE(MAKE_BASE), .PRE_BASE(PRE_BASE), .EN_ADDR(EN_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wr_i(reg_wr), .wdata_i(reg_wdata),
    .rdata_o(reg_rdata), .make_o(make_codes), .pre_o(pre_codes), .pre_en_o(pre_en)
  );

  gsi_pending #(.N(N_PINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .clr_mk_i(clr_mk), .clr_brk_i(clr_brk),
    .mk_o(mk), .brk_o(brk), .brk_first_o(brk_first)
  );

  gsi_sequencer #(.N(N_PINS)) u_seq (
    .clk(clk), .rst_n(rst_n), .mk_i(mk), .brk_i(brk), .brk_first_i(brk_first),
    .make_i(make_codes), .pre_i(pre_codes), .pre_en_i(pre_en), .rd_i(obuf_rd),
    .clr_mk_o(clr_mk), .clr_brk_o(clr_brk),
    .obuf_data_o(obuf_data), .obuf_full_o(obuf_full),
    .tail_pend_o(seq_tail_pend), .tail_byte_o(seq_tail_byte)
  );
endmodule

// File: rtl/gsi_checker.sv
module gsi_checker #(
  parameter logic [7:0] MAKE_BASE = 8'hD8,
  parameter logic [7:0] PRE_BASE  = 8'hC8,
  parameter logic [7:0] EN_ADDR   = 8'hD0,
  parameter int unsigned N_PINS   = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       obuf_rd,
  input logic [7:0] obuf_data,
  input logic       obuf_full,
  input logic       tail_pend,
  input logic [7:0] tail_byte
);
  logic unmapped;
  assign unmapped = !((reg_addr >= MAKE_BASE) && (reg_addr < 8'(MAKE_BASE + N_PINS))) &&
                    !((reg_addr >= PRE_BASE) && (reg_addr < 8'(PRE_BASE + N_PINS))) &&
                    (reg_addr != EN_ADDR);

  a_r6_hold_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    (obuf_full && !obuf_rd) |=> (obuf_full && $stable(obuf_data)));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (obuf_full && obuf_rd) |=> !obuf_full);

  a_r9_tail_next: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_pend && !obuf_full) |=> (obuf_full && obuf_data == $past(tail_byte)));

  a_r9_tail_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_pend && obuf_full) |=> tail_pend);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (reg_rdata == 8'h00));
endmodule

bind gpio_scan_inject gsi_checker #(
  .MAKE_BASE(MAKE_BASE), .PRE_BASE(PRE_BASE), .EN_ADDR(EN_ADDR), .N_PINS(N_PINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .obuf_rd(obuf_rd), .obuf_data(obuf_data), .obuf_full(obuf_full),
  .tail_pend(seq_tail_pend), .tail_byte(seq_tail_byte)
);

// File: tb/test_gpio_scan_inject.sv
`timescale 1ns/1ps
module test_gpio_scan_inject;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] gpio_in = '0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       obuf_rd = 1'b0;
  logic [7:0] obuf_data;
  logic       obuf_full;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  gpio_scan_inject i_gpio_scan_inject (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .obuf_rd(obuf_rd),
    .obuf_data(obuf_data), .obuf_full(obuf_full)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic set_pin(input int p, input bit v);
    @(negedge clk); gpio_in[p] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic peek_byte(input logic [7:0] exp, input string tag);
    int waited = 0;
    while (!obuf_full && waited < 40) begin @(negedge clk); waited++; end
    check(obuf_full == 1'b1, {tag, " full"}, obuf_full, 1);
    check(obuf_data == exp, tag, obuf_data, exp);
  endtask

  task automatic do_read(input string tag);
    obuf_rd = 1'b1;
    @(negedge clk); obuf_rd = 1'b0;
    check(obuf_full == 1'b0, {tag, " flag cleared after read"}, obuf_full, 0);
  endtask

  task automatic get_byte(input logic [7:0] exp, input string tag);
    peek_byte(exp, tag);
    do_read(tag);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (obuf_full) seen = 1; end
    check(!seen, tag, seen, 0);
  endtask

  task automatic t_reset;
    check(obuf_full == 1'b0, "R1 obuf_full", obuf_full, 0);
    for (int i = 0; i < 8; i++) reg_check(8'(8'hD8 + i), 8'h00, "R1 make reset");
    for (int i = 0; i < 8; i++) reg_check(8'(8'hC8 + i), 8'hE0, "R1 prefix reset");
    reg_check(8'hD0, 8'h00, "R1 enable reset");
  endtask

  task automatic t_regmap;
    for (int i = 0; i < 8; i++) reg_write(8'(8'hD8 + i), 8'(8'h10 + i));
    for (int i = 0; i < 8; i++) reg_write(8'(8'hC8 + i), 8'(8'hA0 + i));
    reg_write(8'hD0, 8'h5A);
    for (int i = 0; i < 8; i++) reg_check(8'(8'hD8 + i), 8'(8'h10 + i), "R2 make map");
    for (int i = 0; i < 8; i++) reg_check(8'(8'hC8 + i), 8'(8'hA0 + i), "R2 prefix map");
    reg_check(8'hD0, 8'h5A, "R2 enable map");
    reg_write(8'hD0, 8'h00);
    reg_write(8'hC0, 8'h77);
    reg_write(8'hD5 - 8'h01, 8'h77);
    reg_check(8'hC0, 8'h00, "R2 unmapped read");
    reg_check(8'hD4, 8'h00, "R2 unmapped read gap");
    reg_check(8'hD8, 8'h10, "R2 unmapped write no effect");
    reg_check(8'hCF, 8'hA7, "R2 unmapped write no effect prefix");
    expect_quiet(20, "R11 no byte from register traffic");
  endtask

  task automatic t_press_release;
    set_pin(3, 1); get_byte(8'h13, "R3 press pin3");
    expect_quiet(10, "R11 single byte per press");
    set_pin(3, 0); get_byte(8'h93, "R4 release pin3");
    reg_write(8'hDD, 8'h85);
    set_pin(5, 1); get_byte(8'h85, "R3 press pin5");
    set_pin(5, 0); get_byte(8'h05, "R4 release wraps");
    reg_write(8'hDD, 8'h15);
  endtask

  task automatic t_prefix;
    reg_write(8'hD0, 8'h40);
    set_pin(6, 1);
    get_byte(8'hA6, "R5 prefix before make");
    get_byte(8'h16, "R5 make after prefix");
    set_pin(6, 0);
    get_byte(8'hA6, "R5 prefix before break");
    get_byte(8'h96, "R5 break after prefix");
    reg_write(8'hD0, 8'h00);
  endtask

  task automatic t_hold;
    set_pin(1, 1);
    peek_byte(8'h11, "R6 first byte");
    @(negedge clk); gpio_in[2] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(obuf_full && obuf_data == 8'h11, "R6 held while unread", obuf_data, 8'h11);
    end
    do_read("R7 read");
    get_byte(8'h12, "R7 next byte after read");
    set_pin(1, 0); set_pin(2, 0);
    get_byte(8'h91, "R4 release pin1");
    get_byte(8'h92, "R4 release pin2");
  endtask

  task automatic t_priority;
    set_pin(0, 1);
    peek_byte(8'h10, "R8 blocker");
    set_pin(7, 1); set_pin(4, 1); set_pin(2, 1);
    do_read("R8 blocker");
    get_byte(8'h12, "R8 lowest pin first");
    get_byte(8'h14, "R8 second");
    get_byte(8'h17, "R8 third");
    @(negedge clk); gpio_in = 8'h00;
    repeat (6) @(negedge clk);
    get_byte(8'h90, "R8 release order 0");
    get_byte(8'h92, "R8 release order 2");
    get_byte(8'h94, "R8 release order 4");
    get_byte(8'h97, "R8 release order 7");
  endtask

  task automatic t_no_interleave;
    reg_write(8'hD0, 8'h20);
    set_pin(1, 1);
    peek_byte(8'h11, "R9 blocker");
    set_pin(5, 1);
    do_read("R9 blocker");
    peek_byte(8'hA5, "R9 prefix of pin5");
    set_pin(0, 1);
    do_read("R9 prefix");
    get_byte(8'h15, "R9 tail before higher priority");
    get_byte(8'h10, "R9 pin0 after tail");
    reg_write(8'hD0, 8'h00);
    set_pin(0, 0); set_pin(1, 0); set_pin(5, 0);
    get_byte(8'h90, "R4 cleanup 0");
    get_byte(8'h91, "R4 cleanup 1");
    get_byte(8'h95, "R4 cleanup 5");
  endtask

  task automatic t_pending;
    set_pin(3, 1);
    peek_byte(8'h13, "R10 blocker");
    set_pin(2, 1); set_pin(2, 0); set_pin(2, 1);
    do_read("R10 blocker");
    get_byte(8'h92, "R10 older release first");
    get_byte(8'h12, "R10 newest press last");
    expect_quiet(20, "R10 merged edges give two bytes");
    set_pin(2, 0); set_pin(3, 0);
    get_byte(8'h92, "R10 cleanup 2");
    get_byte(8'h93, "R10 cleanup 3");
    expect_quiet(30, "R11 steady pins quiet");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regmap();
    t_press_release();
    t_prefix();
    t_hold();
    t_priority();
    t_no_interleave();
    t_pending();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end
endmodule